// File: doc/BRIEF.md
# Serial Addressed Control Word Bank

This block receives control words over a three-wire serial link (bit clock, data, enable) and holds them in four parallel control latches. Every rising edge of the bit clock pushes one data bit into a 24-bit shift register, most significant bit first. A rising edge on the enable line commits that register. Its two leading bits pick the target latch. The remaining 22 bits become that latch's new contents. The other three latches keep their values, so one word can be changed without resending the rest.

All three serial pins are synchronized into the system clock domain, and edges are found there. On a synchronous reset, each latch loads a default value. The defaults are picked by a channel strap input and computed from two parameters. Surrounding logic reads all four latches continuously as parallel words.

Top module: `ctl_word_bank`

## Requirements
- R1: On each rising edge of `ser_clk`, the value of `ser_dat` is shifted in at the low end of the 24-bit frame register. The first bit sent ends up as bit 23 of a full frame.
- R2: On commit, frame bits 23:22 select the target word: 00 writes `word_a`, 01 `word_b`, 10 `word_c` and 11 `word_d`. Frame bits 21:0 become that word's value.
- R3: A commit takes place only on a rising edge of `ser_en`. Bit clocks while `ser_en` is high, and the falling edge of `ser_en`, change no output word.
- R4: When more than 24 bits are clocked before a commit, only the last 24 bits received count. The earlier ones are lost.
- R5: A commit leaves the three words that are not addressed unchanged.
- R6: A commit that follows fewer than 24 new bit clocks uses whatever the frame register holds at that time. Older bits fill the upper positions.
- R7: While `rst_n` is low at a `clk` rising edge, word w (0=a, 1=b, 2=c, 3=d) loads the low 22 bits of ((4*p + w + 1) * DEF_MULT) XOR DEF_MIX, where p is `chan_sel`. The parameter defaults are 0x9E37 and 0x155555.
- R8: The addressed word shows its new value by the fourth rising edge of `clk`, counted from the first edge at which `ser_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sel | input | PRESET_W (2) | Channel strap that picks the default set |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Serial enable; its rising edge commits the frame |
| word_a | output | DATA_W (22) | Control word at address 00 |
| word_b | output | DATA_W (22) | Control word at address 01 |
| word_c | output | DATA_W (22) | Control word at address 10 |
| word_d | output | DATA_W (22) | Control word at address 11 |

## Verification
The assertions assume two things about the inputs. First, `ser_dat` is steady across the synchronizer delay around each `ser_clk` rising edge. Second, each level of `ser_clk` and `ser_en` lasts at least two system clocks, which is what a system clock four or more times faster than the bit clock gives. The stimulus changes data three system clocks before raising the bit clock and holds each bit clock level for at least four system clocks. The enable line moves only while the bit clock is low and idle, so the synchronized edges the checks rely on are never merged or lost.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

  // Default control word for one preset/word pair: mixed product of an index and a multiplier.
  function automatic logic [31:0] preset_word(input logic [31:0] preset,
                                              input logic [31:0] idx,
                                              input logic [31:0] n_words,
                                              input logic [31:0] mult,
                                              input logic [31:0] mix);
    logic [31:0] key;
    key = preset * n_words + idx + 32'd1;
    return (key * mult) ^ mix;
  endfunction

  // Target word index carried in the leading bits of a frame.
  function automatic logic [1:0] frame_addr(input logic [23:0] frame);
    return frame[23:22];
  endfunction

endpackage

// File: rtl/cwb_sync.sv
module cwb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/cwb_frontend.sv
module cwb_frontend #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               sen_s,
  output logic [FRAME_W-1:0] frame_q,
  output logic               commit
);

  logic sclk_prev, sen_prev;
  logic sclk_rise, sen_rise;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sen_rise  = sen_s & ~sen_prev;
  assign commit    = sen_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sen_prev  <= 1'b0;
      frame_q   <= '0;
    end else begin
      sclk_prev <= sclk_s;
      sen_prev  <= sen_s;
      if (sclk_rise) frame_q <= {frame_q[FRAME_W-2:0], sdat_s};
    end
  end

  // R1: a bit clock edge shifts the sampled data bit in at the low end
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> frame_q == {$past(frame_q[FRAME_W-2:0]), $past(sdat_s)});

  // R4: without a bit clock edge the frame register keeps its contents
  a_r4_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(frame_q));

endmodule

// File: rtl/cwb_bank.sv
module cwb_bank #(
  parameter int          DATA_W    = 22,
  parameter int          ADDR_W    = 2,
  parameter int          PRESET_W  = 2,
  parameter logic [31:0] DEF_MULT  = 32'h9E37,
  parameter logic [31:0] DEF_MIX   = 32'h155555,
  localparam int         NUM_WORDS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRESET_W-1:0] chan_sel,
  input  logic                commit,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   words [NUM_WORDS]
);

  logic [NUM_WORDS-1:0] wr_en;

  generate
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      logic [31:0] dflt;
      assign wr_en[i] = commit && (wr_addr == ADDR_W'(i));
      assign dflt = cwb_pkg::preset_word(32'(chan_sel), 32'(i), 32'(NUM_WORDS),
                                         DEF_MULT, DEF_MIX);

      always_ff @(posedge clk) begin
        if (!rst_n)        words[i] <= dflt[DATA_W-1:0];
        else if (wr_en[i]) words[i] <= wr_data;
      end

      // R2: the addressed word takes the frame data one clock after commit
      a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[i] |=> words[i] == $past(wr_data));

      // R5: a word that is not addressed keeps its value
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[i] |=> $stable(words[i]));
    end
  endgenerate

  // R3: a word can only change when the front end signals a commit
  a_r3_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(words[0]) && $stable(words[NUM_WORDS-1]));

endmodule

// File: rtl/ctl_word_bank.sv
module ctl_word_bank #(
  parameter int          DATA_W      = 22,
  parameter int          SYNC_STAGES = 2,
  parameter int          PRESET_W    = 2,
  parameter logic [31:0] DEF_MULT    = 32'h9E37,
  parameter logic [31:0] DEF_MIX     = 32'h155555
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRESET_W-1:0] chan_sel,
  input  logic                ser_clk,
  input  logic                ser_dat,
  input  logic                ser_en,
  output logic [DATA_W-1:0]   word_a,
  output logic [DATA_W-1:0]   word_b,
  output logic [DATA_W-1:0]   word_c,
  output logic [DATA_W-1:0]   word_d
);

  localparam int ADDR_W    = 2;
  localparam int NUM_WORDS = 1 << ADDR_W;
  localparam int FRAME_W   = DATA_W + ADDR_W;

  logic [2:0]          pins_sync;
  logic [FRAME_W-1:0]  frame_q;
  logic                commit;
  logic [DATA_W-1:0]   words [NUM_WORDS];

  cwb_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ser_en, ser_dat, ser_clk}),
    .d_sync  (pins_sync)
  );

  cwb_frontend #(.FRAME_W(FRAME_W)) front_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_sync[0]),
    .sdat_s  (pins_sync[1]),
    .sen_s   (pins_sync[2]),
    .frame_q (frame_q),
    .commit  (commit)
  );

  cwb_bank #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PRESET_W (PRESET_W),
    .DEF_MULT (DEF_MULT),
    .DEF_MIX  (DEF_MIX)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_sel (chan_sel),
    .commit   (commit),
    .wr_addr  (frame_q[FRAME_W-1 -: ADDR_W]),
    .wr_data  (frame_q[DATA_W-1:0]),
    .words    (words)
  );

  assign word_a = words[0];
  assign word_b = words[1];
  assign word_c = words[2];
  assign word_d = words[3];

  // R3: a commit needs the enable pin to have been high after being low
  a_r3_commit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(ser_en, SYNC_STAGES));

endmodule

// File: tb/ctl_word_bank_tb_top.sv
module ctl_word_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_sel = 2'd0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_en = 1'b0;
  logic [21:0] word_a, word_b, word_c, word_d;

  int checks = 0;
  int failures = 0;

  logic [23:0] mdl_frame = '0;
  logic [21:0] mdl_word [4];
  logic [23:0] exp_q [$];
  event        chk_ev;

  always #10 clk = ~clk;

  ctl_word_bank dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .word_a(word_a), .word_b(word_b), .word_c(word_c), .word_d(word_d)
  );

  function automatic logic [21:0] dflt(input int p, input int w);
    logic [31:0] prod;
    prod = 32'(4*p + w + 1) * 32'h9E37;
    return 22'(prod ^ 32'h155555);
  endfunction

  function automatic logic [21:0] dut_word(input int w);
    case (w)
      0: return word_a;
      1: return word_b;
      2: return word_c;
      default: return word_d;
    endcase
  endfunction

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) check(req, dut_word(w), mdl_word[w]);
  endtask

  task automatic do_reset(input logic [1:0] p);
    @(negedge clk);
    rst_n = 1'b0; chan_sel = p;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mdl_frame = '0;
    for (int w = 0; w < 4; w++) mdl_word[w] = dflt(int'(p), w);
    @(negedge clk);
    check_all("R7 reset default");
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    mdl_frame = {mdl_frame[22:0], b};
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic [63:0] v);
    for (int i = n-1; i >= 0; i--) send_bit(v[i]);
  endtask

  // Driver: raise enable, push the expected frame, let the monitor compare at the R8 deadline.
  task automatic commit_frame();
    @(negedge clk); ser_en = 1'b1;
    exp_q.push_back(mdl_frame);
    repeat (4) @(posedge clk);
    @(negedge clk);
    -> chk_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic drop_en();
    @(negedge clk); ser_en = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R3 falling enable");
  endtask

  // Monitor: pop the expected frame, apply it to the model and compare every word.
  initial begin
    forever begin
      logic [23:0] f;
      @(chk_ev);
      f = exp_q.pop_front();
      for (int w = 0; w < 4; w++) begin
        if (w == int'(f[23:22])) begin
          mdl_word[w] = f[21:0];
          check("R2 R8 addressed word", dut_word(w), mdl_word[w]);
        end else begin
          check("R5 other word", dut_word(w), mdl_word[w]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(2'd2);

    // R1 R2: one full frame per address, MSB first
    send_bits(24, {40'd0, 2'b00, 22'h2AB3C1}); commit_frame(); drop_en();
    send_bits(24, {40'd0, 2'b01, 22'h13579B}); commit_frame(); drop_en();
    send_bits(24, {40'd0, 2'b10, 22'h0F0F0F}); commit_frame(); drop_en();
    send_bits(24, {40'd0, 2'b11, 22'h3C03C0}); commit_frame(); drop_en();

    // R5: rewrite one word only
    send_bits(24, {40'd0, 2'b01, 22'h000001}); commit_frame(); drop_en();

    // R4: six extra leading bits are discarded
    send_bits(30, {34'd0, 6'b101110, 2'b11, 22'h01F00F}); commit_frame(); drop_en();
    check("R4 long frame word_d", word_d, 22'h01F00F);

    // R6: short frame of eight bits commits the current register
    send_bits(8, 64'hA5); commit_frame(); drop_en();
    check("R6 short frame word_d", word_d, 22'h300FA5);

    // R3: bit clocks while enable is high do not commit
    send_bits(24, {40'd0, 2'b00, 22'h111111});
    @(negedge clk); ser_en = 1'b1;
    repeat (6) @(negedge clk);
    exp_q.push_back(mdl_frame); -> chk_ev;
    repeat (2) @(negedge clk);
    send_bits(24, {40'd0, 2'b00, 22'h222222});
    check_all("R3 clocks while enable high");
    drop_en();

    // R7: second strap value
    do_reset(2'd1);
    send_bits(24, {40'd0, 2'b10, 22'h3FFFFF}); commit_frame(); drop_en();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule